// File: doc/BRIEF.md
# Inter-Processor Software Interrupt Dispatcher

This block raises and retires software interrupts that one CPU sends to other CPUs of a multi-processor interrupt controller. A CPU posts an interrupt by writing a 32-bit trigger word. The word names a software interrupt number, a list of destination CPUs and a filter mode that picks the destinations. For every pair of destination CPU and interrupt number, the block keeps a bitmap of the CPUs that posted that interrupt. It also keeps a pending flag for each pair, and these flags are driven out to the rest of the controller.

A destination CPU retires an interrupt by acknowledging its number. The block picks the lowest-numbered posting CPU, removes that CPU from the bitmap and returns the interrupt number with the source number folded in. The pending flag drops only when no posting CPU is left. Each CPU can also reach its own bitmaps directly through two windows of byte registers, one that removes source bits and one that adds them. Both windows read back the current bitmap. Every access carries the number of the CPU that makes it.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset every source bitmap and every pending flag is zero, and an acknowledge returns 1023.
- R2: A write to offset 0xF00 is a trigger. The interrupt number is in bits 9:0, the destination list in bits 23:16 (bit 16 is CPU 0) and the filter mode in bits 25:24. A trigger whose number is NID or more changes nothing.
- R3: Filter mode 0 sends to the CPUs in the destination list. Mode 1 sends to every CPU except the requester. Mode 2 sends to the requester only. Mode 3 sends to every CPU.
- R4: For each selected destination, a trigger sets the requester's bit in that destination's bitmap for the number and sets the matching pending flag. Pending flag index = destination*NID + number.
- R5: An acknowledge from CPU c for number n with a non-empty bitmap chooses the lowest set source s, clears that bit and returns n | ((s & 7) << 10).
- R6: After an acknowledge, the pending flag stays set while sources remain and is cleared when the bitmap becomes empty.
- R7: An acknowledge of a number whose bitmap is empty, or of a number of NID or more, returns 1023 and changes no bitmap and no pending flag.
- R8: A write to 0xF10+n clears the written source bits in the accessing CPU's bitmap for n. If that bitmap is then empty, its pending flag is cleared.
- R9: A write to 0xF20+n ORs the written source bits into the accessing CPU's bitmap for n and sets its pending flag. A written value of zero still sets the flag.
- R10: A read of 0xF10+n or 0xF20+n returns the accessing CPU's bitmap for n in bits NCPU-1:0, with zeros above. Reads of other offsets return zero.
- R11: Destination list bits for CPUs at or above NCPU, and written source bits at or above NCPU, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_cpu | input | CPU_W | Number of the CPU that makes the access or acknowledge |
| acc_addr | input | 12 | Register offset of the access |
| acc_wr | input | 1 | Write strobe for the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for acc_addr (combinational) |
| ack_en | input | 1 | Acknowledge request from acc_cpu |
| ack_id | input | 10 | Interrupt number that is acknowledged |
| ack_val | output | 32 | Acknowledge result (combinational), 1023 if nothing was taken |
| pend_o | output | NCPU*NID | Pending flags, index destination*NID + number |

## Verification
The bench sends every requester with every filter mode and several destination lists, then drains each destination by acknowledge. A wrong filter decode would raise flags on the wrong CPUs. A design that drops pending after the first acknowledge would lose the sources that are still queued, so the bench acknowledges four sources of one number in order and checks the encoded source field each time. Two corner cases use the byte windows. A zero write to the set window leaves a flag with an empty bitmap, which must then give a spurious acknowledge without clearing the flag, and a zero write to the clear window must then clear it. Out-of-range numbers and destination or source bits above the CPU count must leave all state unchanged.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

  typedef enum logic [1:0] {
    FLT_LIST   = 2'd0,
    FLT_OTHERS = 2'd1,
    FLT_SELF   = 2'd2,
    FLT_ALL    = 2'd3
  } sgi_filter_e;

  localparam int unsigned OFS_W = 12;
  localparam logic [OFS_W-1:0] TRIG_OFS = 12'hF00;
  localparam logic [OFS_W-1:0] CLR_OFS  = 12'hF10;
  localparam logic [OFS_W-1:0] SET_OFS  = 12'hF20;
  localparam logic [9:0]       SPURIOUS = 10'd1023;

endpackage

// File: rtl/sgi_target_decode.sv
module sgi_target_decode
  import sgi_pkg::*;
#(
  parameter int unsigned NCPU  = 4,
  parameter int unsigned CPU_W = 2
) (
  input  logic [CPU_W-1:0] req_cpu,
  input  sgi_filter_e      filter,
  input  logic [7:0]       dest_list,
  output logic [NCPU-1:0]  dest
);

  for (genvar t = 0; t < NCPU; t++) begin : g_dest
    logic is_self;
    assign is_self = (req_cpu == CPU_W'(t));
    assign dest[t] = (filter == FLT_LIST)   ? dest_list[t] :
                     (filter == FLT_OTHERS) ? !is_self     :
                     (filter == FLT_SELF)   ? is_self      : 1'b1;
  end

endmodule

// File: rtl/sgi_lowest_pick.sv
module sgi_lowest_pick #(
  parameter int unsigned W     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [W-1:0]     vec,
  output logic [W-1:0]     onehot,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    onehot = '0;
    idx    = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (vec[k]) begin
        onehot = W'(1) << k;
        idx    = IDX_W'(k);
      end
    end
  end

endmodule

// File: rtl/sgi_cell.sv
module sgi_cell #(
  parameter int unsigned NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig_hit,
  input  logic            set_hit,
  input  logic            clr_hit,
  input  logic            ack_hit,
  input  logic [NCPU-1:0] src_bit,
  input  logic [NCPU-1:0] wr_bits,
  input  logic [NCPU-1:0] ack_bit,
  output logic [NCPU-1:0] bits_q,
  output logic            pend_q
);

  logic [NCPU-1:0] bits_d;
  logic            pend_d;
  logic            upd;

  assign upd = trig_hit | set_hit | clr_hit | ack_hit;

  // acknowledge is applied first, a register write lands on its result
  always_comb begin
    bits_d = bits_q;
    pend_d = pend_q;
    if (ack_hit && (bits_q != '0)) begin
      bits_d = bits_q & ~ack_bit;
      if (bits_d == '0) pend_d = 1'b0;
    end
    if (trig_hit) begin
      bits_d = bits_d | src_bit;
      pend_d = 1'b1;
    end
    if (set_hit) begin
      bits_d = bits_d | wr_bits;
      pend_d = 1'b1;
    end
    if (clr_hit) begin
      bits_d = bits_d & ~wr_bits;
      if (bits_d == '0) pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      pend_q <= 1'b0;
    end else if (upd) begin
      bits_q <= bits_d;
      pend_q <= pend_d;
    end
  end

  // R6
  nonempty_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bits_q != '0) |-> pend_q);

  // R4
  trig_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |=> ((bits_q & $past(src_bit)) != '0) && pend_q);

  // R5
  ack_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !trig_hit && !set_hit && !clr_hit && (bits_q != '0))
    |=> ($countones(bits_q) + 1 == $countones($past(bits_q))));

endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int unsigned NCPU  = 4,
  parameter int unsigned NID   = 16,
  parameter int unsigned CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CPU_W-1:0]     acc_cpu,
  input  logic [OFS_W-1:0]     acc_addr,
  input  logic                 acc_wr,
  input  logic [31:0]          acc_wdata,
  output logic [31:0]          acc_rdata,
  input  logic                 ack_en,
  input  logic [9:0]           ack_id,
  output logic [31:0]          ack_val,
  output logic [NCPU*NID-1:0]  pend_o
);

  localparam int unsigned ID_W   = (NID > 1) ? $clog2(NID) : 1;
  localparam int unsigned NCELL  = NCPU * NID;

  // access decode
  logic [OFS_W-1:0] clr_off, set_off;
  logic             in_clr, in_set;
  logic [ID_W-1:0]  reg_id;
  logic             is_trig, trig_ok;
  logic [9:0]       trig_id;
  logic [NCPU-1:0]  dest;
  logic [NCPU-1:0]  req_bit;

  assign clr_off = acc_addr - CLR_OFS;
  assign set_off = acc_addr - SET_OFS;
  assign in_clr  = (acc_addr >= CLR_OFS) && (clr_off < OFS_W'(NID));
  assign in_set  = (acc_addr >= SET_OFS) && (set_off < OFS_W'(NID));
  assign reg_id  = in_clr ? clr_off[ID_W-1:0] : set_off[ID_W-1:0];
  assign is_trig = acc_wr && (acc_addr == TRIG_OFS);
  assign trig_id = acc_wdata[9:0];
  assign trig_ok = (trig_id < 10'(NID));
  assign req_bit = NCPU'(1) << acc_cpu;

  sgi_target_decode #(.NCPU(NCPU), .CPU_W(CPU_W)) u_dest (
    .req_cpu   (acc_cpu),
    .filter    (sgi_filter_e'(acc_wdata[25:24])),
    .dest_list (acc_wdata[23:16]),
    .dest      (dest)
  );

  // acknowledge selection
  logic [NCPU-1:0]  bits_all [NCELL];
  logic [NCPU-1:0]  ack_bits, ack_onehot;
  logic [CPU_W-1:0] ack_src;
  logic             ack_ok, ack_go;
  logic [2:0]       src3;
  int unsigned      ack_sel, rd_sel;

  assign ack_ok  = (ack_id < 10'(NID));
  assign ack_sel = int'(acc_cpu) * NID + int'(ack_id[ID_W-1:0]);
  assign ack_bits = ack_ok ? bits_all[ack_sel] : '0;
  assign ack_go  = ack_en && (ack_bits != '0);

  sgi_lowest_pick #(.W(NCPU), .IDX_W(CPU_W)) u_pick (
    .vec    (ack_bits),
    .onehot (ack_onehot),
    .idx    (ack_src)
  );

  always_comb begin
    src3 = 3'(ack_src);
    if (ack_go) ack_val = {19'd0, src3, ack_id};
    else        ack_val = {22'd0, SPURIOUS};
  end

  // storage
  for (genvar t = 0; t < NCPU; t++) begin : g_tgt
    for (genvar i = 0; i < NID; i++) begin : g_id
      logic own, hit_trig, hit_set, hit_clr, hit_ack;
      assign own      = (acc_cpu == CPU_W'(t));
      assign hit_trig = is_trig && trig_ok && (trig_id == 10'(i)) && dest[t];
      assign hit_set  = acc_wr && in_set && own && (reg_id == ID_W'(i));
      assign hit_clr  = acc_wr && in_clr && own && (reg_id == ID_W'(i));
      assign hit_ack  = ack_go && own && (ack_id == 10'(i));

      sgi_cell #(.NCPU(NCPU)) u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_hit (hit_trig),
        .set_hit  (hit_set),
        .clr_hit  (hit_clr),
        .ack_hit  (hit_ack),
        .src_bit  (req_bit),
        .wr_bits  (acc_wdata[NCPU-1:0]),
        .ack_bit  (ack_onehot),
        .bits_q   (bits_all[t*NID+i]),
        .pend_q   (pend_o[t*NID+i])
      );
    end
  end

  // read path
  assign rd_sel    = int'(acc_cpu) * NID + int'(reg_id);
  assign acc_rdata = (in_clr || in_set) ? 32'(bits_all[rd_sel]) : 32'd0;

  // assertion helpers
  int unsigned self_idx;
  assign self_idx = int'(acc_cpu) * NID + int'(trig_id[ID_W-1:0]);

  // R3
  self_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_trig && trig_ok && (acc_wdata[25:24] == 2'd2)) |=> pend_o[$past(self_idx)]);

  // R5
  ack_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && (ack_val[9:0] != SPURIOUS)) |-> (ack_val[9:0] == ack_id) && pend_o[ack_sel]);

  // R7
  spurious_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && (ack_val[9:0] == SPURIOUS) && !acc_wr) |=> $stable(pend_o));

  // R2
  bad_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_trig && !trig_ok && !ack_en) |=> $stable(pend_o));

endmodule

// File: tb/sgi_dispatch_tb_top.sv
`timescale 1ns/1ps
module sgi_dispatch_tb_top;

  localparam int NC = 4;
  localparam int NI = 16;

  logic        clk, rst_n;
  logic [1:0]  acc_cpu;
  logic [11:0] acc_addr;
  logic        acc_wr;
  logic [31:0] acc_wdata, acc_rdata;
  logic        ack_en;
  logic [9:0]  ack_id;
  logic [31:0] ack_val;
  logic [63:0] pend_o;

  sgi_dispatch #(.NCPU(NC), .NID(NI)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_cpu(acc_cpu), .acc_addr(acc_addr),
    .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .ack_en(ack_en), .ack_id(ack_id), .ack_val(ack_val), .pend_o(pend_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  logic [3:0] bm [NC][NI];
  logic       pd [NC][NI];

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_pend();
    logic [63:0] v = '0;
    for (int t = 0; t < NC; t++)
      for (int i = 0; i < NI; i++) v[t*NI+i] = pd[t][i];
    return v;
  endfunction

  task automatic write(int c, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    acc_cpu = 2'(c); acc_addr = a; acc_wdata = d; acc_wr = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0; acc_addr = 12'h000; acc_wdata = '0;
  endtask

  task automatic trigger(int c, logic [31:0] d);
    int id = int'(d[9:0]);
    logic [3:0] m;
    case (d[25:24])
      2'd0: m = d[19:16];
      2'd1: m = 4'hF & ~(4'd1 << c);
      2'd2: m = 4'd1 << c;
      default: m = 4'hF;
    endcase
    write(c, 12'hF00, d);
    if (id < NI)
      for (int t = 0; t < NC; t++)
        if (m[t]) begin bm[t][id] |= (4'd1 << c); pd[t][id] = 1'b1; end
  endtask

  task automatic setw(int c, int id, logic [31:0] d);
    write(c, 12'hF20 + 12'(id), d);
    bm[c][id] |= d[3:0]; pd[c][id] = 1'b1;
  endtask

  task automatic clrw(int c, int id, logic [31:0] d);
    write(c, 12'hF10 + 12'(id), d);
    bm[c][id] &= ~d[3:0];
    if (bm[c][id] == 0) pd[c][id] = 1'b0;
  endtask

  task automatic ack(string tag, int c, int id);
    logic [31:0] e;
    @(negedge clk);
    acc_cpu = 2'(c); ack_id = 10'(id); ack_en = 1'b1;
    #1;
    e = 32'd1023;
    if (id < NI && bm[c][id] != 0) begin
      int s = 0;
      while (!bm[c][id][s]) s++;
      e = 32'(id) | (32'(s & 7) << 10);
      bm[c][id][s] = 1'b0;
      if (bm[c][id] == 0) pd[c][id] = 1'b0;
    end
    chk(tag, 64'(ack_val), 64'(e));
    @(negedge clk);
    ack_en = 1'b0;
  endtask

  task automatic rd_chk(string tag, int c, logic [11:0] a, logic [31:0] e);
    acc_cpu = 2'(c); acc_addr = a; acc_wr = 1'b0;
    #1;
    chk(tag, 64'(acc_rdata), 64'(e));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [7:0] lists [4] = '{8'h00, 8'h05, 8'h0A, 8'hF6};
    for (int t = 0; t < NC; t++)
      for (int i = 0; i < NI; i++) begin bm[t][i] = '0; pd[t][i] = 1'b0; end
    rst_n = 1'b0; acc_cpu = '0; acc_addr = '0; acc_wr = 1'b0; acc_wdata = '0;
    ack_en = 1'b0; ack_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pend after reset", pend_o, 64'd0);
    ack("R1 ack after reset", 0, 0);

    // R2 R3 R4 R6 R11 sweep: requester x filter x list
    for (int rq = 0; rq < NC; rq++)
      for (int f = 0; f < 4; f++)
        for (int l = 0; l < 4; l++) begin
          int id = (rq * 4 + f + l * 5) % NI;
          trigger(rq, {6'd0, 2'(f), lists[l], 6'd0, 10'(id)});
          chk("R3 R4 R11 pend after trigger", pend_o, exp_pend());
          for (int c = 0; c < NC; c++)
            rd_chk("R10 R4 bitmap read", c, 12'hF20 + 12'(id), 32'(bm[c][id]));
          for (int c = 0; c < NC; c++) begin
            ack("R5 R7 drain ack", c, id);
            chk("R6 pend after drain", pend_o, exp_pend());
          end
        end

    // R5 R6 four sources queued at CPU 0, number 7
    for (int s = NC - 1; s >= 0; s--) trigger(s, {6'd0, 2'd0, 8'h01, 6'd0, 10'd7});
    rd_chk("R4 four sources", 0, 12'hF10 + 12'd7, 32'hF);
    for (int k = 0; k < NC; k++) begin
      ack("R5 ordered source", 0, 7);
      chk("R6 pend while draining", pend_o, exp_pend());
    end
    ack("R7 empty bitmap ack", 0, 7);
    ack("R7 out-of-range ack", 1, 40);

    // R2 out-of-range trigger
    trigger(2, {6'd0, 2'd3, 8'h00, 6'd0, 10'd20});
    chk("R2 out-of-range trigger", pend_o, 64'd0);

    // R9 R7 R8 zero writes
    setw(2, 3, 32'd0);
    chk("R9 zero set raises pend", pend_o, exp_pend());
    ack("R7 pend but empty bitmap", 2, 3);
    chk("R7 pend kept", pend_o, exp_pend());
    clrw(2, 3, 32'd0);
    chk("R8 zero clear drops pend", pend_o, exp_pend());

    // R11 R8 high source bits
    setw(1, 5, 32'hF3);
    rd_chk("R11 high source bits dropped", 1, 12'hF20 + 12'd5, 32'h3);
    clrw(1, 5, 32'h1);
    chk("R8 partial clear keeps pend", pend_o, exp_pend());
    rd_chk("R8 clear window read", 1, 12'hF10 + 12'd5, 32'h2);
    clrw(1, 5, 32'h2);
    chk("R8 last clear drops pend", pend_o, exp_pend());

    // R10 other offsets and other CPU view
    setw(3, 15, 32'h5);
    rd_chk("R10 other cpu sees empty", 0, 12'hF20 + 12'd15, 32'h0);
    rd_chk("R10 owner sees bits", 3, 12'hF1F, 32'h5);
    rd_chk("R10 outside window", 3, 12'hF30, 32'h0);
    rd_chk("R10 trigger offset reads zero", 3, 12'hF00, 32'h0);
    ack("R5 set-window source", 3, 15);
    ack("R5 second set-window source", 3, 15);
    chk("R6 all clear", pend_o, 64'd0);

    summary();
  end

endmodule